// File: doc/BRIEF.md
# String Scan Execution Sequencer

This block runs a scan-string operation on behalf of an execution pipeline. At a start strobe it captures an accumulator value, a starting index, an element size (byte, word or doubleword), an address width (16 or 32 bit), a direction flag, a repeat count and a repeat mode. It then fetches elements one at a time through a request/valid read port, addressed by the current index. For each element it subtracts the element from the accumulator at the element's width and keeps only the six arithmetic status flags. After each compare the index moves by the element size.

In the once mode exactly one element is compared. In the repeat modes the count is decremented per element and the loop ends when the count reaches zero. The two conditional modes also stop early on a match or on a mismatch. The memory segment is implied and fixed, so the read address is the index alone. A single-cycle done pulse marks the end of an operation. After that pulse the final index, count and flags are held until the next start.

Top module: `strscan_seq`

## Requirements
- R1: `size_i` selects the compare width: 0 = byte (bits 7:0), 1 = word (bits 15:0), 2 or 3 = doubleword (bits 31:0). The bits of the accumulator and of the element above that width have no effect on the flags.
- R2: `flags_o` bit 0 is CF, set on an unsigned borrow of accumulator minus element. Bit 3 is ZF, set when the difference is zero. Bit 4 is SF, the top bit of the difference at the element width. Bit 5 is OF, set on a signed overflow of the subtraction.
- R3: `flags_o` bit 2 is AF, set on a borrow out of bit 3. `flags_o` bit 1 is PF, set when the low byte of the difference has an even number of ones.
- R4: After each compared element the index moves by 1, 2 or 4 for byte, word or doubleword. It increases when `dir_i` = 0 and decreases when `dir_i` = 1.
- R5: With `wide_addr_i` = 0, only index bits 15:0 step, wrapping within 16 bits, and bits 31:16 are kept. The read address is the low 16 bits, zero-extended. With `wide_addr_i` = 1, all 32 bits step and the read address is the full index.
- R6: While an element is outstanding, `mem_req_o` stays high and `mem_addr_o` stays stable until `mem_rvalid_i`. Each accepted response consumes exactly one element.
- R7: `mode_i` = 0 (once) compares exactly one element and leaves `count_o` equal to the captured count.
- R8: `mode_i` = 1 (repeat by count) decrements `count_o` once per element and ends when it reaches zero. A zero starting count in any repeat mode issues no read, keeps the flags, and pulses done in the next cycle.
- R9: `mode_i` = 2 (repeat while equal) also ends after an element whose ZF is 0. `mode_i` = 3 (repeat while not equal) also ends after an element whose ZF is 1.
- R10: `done_o` is high for exactly one cycle, the cycle after the last element is accepted. `busy_o` is high from the start until that done cycle. A start while busy is ignored, and the index, count and flags do not change while idle.
- R11: After reset the index, count and flags are zero, with no request, not busy and not done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| size_i | input | 2 | Element size code |
| wide_addr_i | input | 1 | 1 = 32-bit index, 0 = 16-bit index |
| dir_i | input | 1 | Direction: 0 up, 1 down |
| acc_i | input | 32 | Accumulator value |
| index_i | input | 32 | Starting index |
| count_i | input | 32 | Starting repeat count |
| mode_i | input | 2 | 0 once, 1 count, 2 while equal, 3 while not equal |
| mem_req_o | output | 1 | Read request, held until response |
| mem_addr_o | output | 32 | Read address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read data, element in the low bits |
| index_o | output | 32 | Current or final index |
| count_o | output | 32 | Current or remaining count |
| flags_o | output | 6 | {OF, SF, ZF, AF, PF, CF} |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
The assertions watch properties that hold on every cycle. They check that a request holds its address until a response, that a counted element lowers the count by one, and that the once mode ends at once with the count untouched. They also check that a zero count finishes without a read, that 16-bit stepping keeps the upper index bits, that the equal mode ends on a mismatch, that done lasts one cycle, and that idle outputs stay still. The actual flag values for particular operands only show up in the bench scenarios. So do wraparound at the 16-bit boundary, downward doubleword stepping, the exact element at which the conditional modes stop, and a start that arrives in mid-run. The bench compares all of these against its behavioural model on every clock.

// File: rtl/strscan_pkg.sv
package strscan_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } elem_sz_e;

  typedef enum logic [1:0] {
    RM_ONCE     = 2'd0,
    RM_COUNT    = 2'd1,
    RM_WHILE_EQ = 2'd2,
    RM_WHILE_NE = 2'd3
  } rep_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  localparam int FLAG_W = 6;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_AF  = 2;
  localparam int FL_ZF  = 3;
  localparam int FL_SF  = 4;
  localparam int FL_OF  = 5;

endpackage

// File: rtl/strscan_rst_sync.sv
module strscan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/strscan_flags.sv
module strscan_flags
  import strscan_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]     acc_i,
  input  logic [DW-1:0]     elem_i,
  input  elem_sz_e          size_i,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int LOW_W = 8;
  localparam int MID_W = 16;

  int              msb_pos;
  logic [DW-1:0]   width_mask;
  logic [DW-1:0]   a_m;
  logic [DW-1:0]   b_m;
  logic [DW:0]     ext_diff;
  logic [DW-1:0]   res;
  logic [4:0]      nib_diff;
  logic            sa;
  logic            sb;
  logic            sr;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: msb_pos = LOW_W - 1;
      SZ_WORD: msb_pos = MID_W - 1;
      default: msb_pos = DW - 1;
    endcase
    width_mask = {DW{1'b1}} >> (DW - 1 - msb_pos);
    a_m        = acc_i & width_mask;
    b_m        = elem_i & width_mask;
    ext_diff   = {1'b0, a_m} - {1'b0, b_m};
    res        = ext_diff[DW-1:0] & width_mask;
    nib_diff   = {1'b0, a_m[3:0]} - {1'b0, b_m[3:0]};
    sa         = a_m[msb_pos];
    sb         = b_m[msb_pos];
    sr         = res[msb_pos];

    flags_o        = '0;
    flags_o[FL_CF] = ext_diff[DW];
    flags_o[FL_PF] = ~^res[LOW_W-1:0];
    flags_o[FL_AF] = nib_diff[4];
    flags_o[FL_ZF] = (res == '0);
    flags_o[FL_SF] = sr;
    flags_o[FL_OF] = (sa ^ sb) & (sa ^ sr);
  end

endmodule

// File: rtl/strscan_step.sv
module strscan_step
  import strscan_pkg::*;
#(
  parameter int IW = 32,
  parameter int SW = 16
) (
  input  logic [IW-1:0] idx_i,
  input  elem_sz_e      size_i,
  input  logic          dir_i,
  input  logic          wide_i,
  output logic [IW-1:0] idx_o
);

  logic [2:0]    stride;
  logic [IW-1:0] stride_ext;
  logic [IW-1:0] full_next;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: stride = 3'd1;
      SZ_WORD: stride = 3'd2;
      default: stride = 3'd4;
    endcase
    stride_ext = {{(IW-3){1'b0}}, stride};
    full_next  = dir_i ? (idx_i - stride_ext) : (idx_i + stride_ext);
  end

  generate
    if (IW > SW) begin : g_split
      assign idx_o = wide_i ? full_next : {idx_i[IW-1:SW], full_next[SW-1:0]};
    end else begin : g_flat
      assign idx_o = full_next;
    end
  endgenerate

endmodule

// File: rtl/strscan_seq.sv
module strscan_seq
  import strscan_pkg::*;
#(
  parameter int IDX_W   = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic              wide_addr_i,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [1:0]        mode_i,
  output logic              mem_req_o,
  output logic [IDX_W-1:0]  mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  index_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int HI_W = IDX_W - SHORT_W;

  logic        rst_sync_n;
  seq_state_e  state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_step;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_dec;
  logic [FLAG_W-1:0] flags_q, flags_d, flags_new;
  elem_sz_e    size_q;
  rep_mode_e   mode_q;
  logic        dir_q, wide_q;
  logic [DATA_W-1:0] acc_q;
  logic        cfg_en, elem_en, idx_en, cnt_en, flags_en, last_elem;

  strscan_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  strscan_flags #(.DW(DATA_W)) i_flags (
    .acc_i   (acc_q),
    .elem_i  (mem_rdata_i),
    .size_i  (size_q),
    .flags_o (flags_new)
  );

  strscan_step #(.IW(IDX_W), .SW(SHORT_W)) i_step (
    .idx_i  (idx_q),
    .size_i (size_q),
    .dir_i  (dir_q),
    .wide_i (wide_q),
    .idx_o  (idx_step)
  );

  assign cnt_dec = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
  assign cfg_en  = (state_q == ST_IDLE) && start_i;
  assign elem_en = (state_q == ST_ACT) && mem_rvalid_i;

  always_comb begin
    unique case (mode_q)
      RM_ONCE:     last_elem = 1'b1;
      RM_COUNT:    last_elem = (cnt_dec == '0);
      RM_WHILE_EQ: last_elem = (cnt_dec == '0) || !flags_new[FL_ZF];
      default:     last_elem = (cnt_dec == '0) || flags_new[FL_ZF];
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    flags_d  = flags_q;
    idx_en   = 1'b0;
    cnt_en   = 1'b0;
    flags_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          idx_d  = index_i;
          cnt_d  = count_i;
          idx_en = 1'b1;
          cnt_en = 1'b1;
          if ((rep_mode_e'(mode_i) != RM_ONCE) && (count_i == '0)) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_ACT;
          end
        end
      end
      ST_ACT: begin
        if (mem_rvalid_i) begin
          idx_d    = idx_step;
          flags_d  = flags_new;
          idx_en   = 1'b1;
          flags_en = 1'b1;
          if (mode_q != RM_ONCE) begin
            cnt_d  = cnt_dec;
            cnt_en = 1'b1;
          end
          if (last_elem) begin
            state_d = ST_DONE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      size_q <= SZ_BYTE;
      mode_q <= RM_ONCE;
      dir_q  <= 1'b0;
      wide_q <= 1'b0;
      acc_q  <= '0;
    end else if (cfg_en) begin
      size_q <= elem_sz_e'(size_i);
      mode_q <= rep_mode_e'(mode_i);
      dir_q  <= dir_i;
      wide_q <= wide_addr_i;
      acc_q  <= acc_i;
    end
  end

  assign mem_req_o  = (state_q == ST_ACT);
  assign mem_addr_o = wide_q ? idx_q : {{HI_W{1'b0}}, idx_q[SHORT_W-1:0]};
  assign index_o    = idx_q;
  assign count_o    = cnt_q;
  assign flags_o    = flags_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_o && mem_rvalid_i && (mode_q != RM_ONCE)) |=> (count_o == $past(count_o) - 1));

  // R7
  once_end_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_o && mem_rvalid_i && (mode_q == RM_ONCE)) |=> (done_o && $stable(count_o)));

  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_o && (mode_i != 2'd0) && (count_i == '0))
      |=> (done_o && !mem_req_o && $stable(flags_o)));

  // R5
  short_index_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_o && mem_rvalid_i && !wide_q)
      |=> (index_o[IDX_W-1:SHORT_W] == $past(index_o[IDX_W-1:SHORT_W])));

  // R9
  while_eq_stop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_o && mem_rvalid_i && (mode_q == RM_WHILE_EQ) && !flags_new[FL_ZF]) |=> done_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> (!done_o && !busy_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_o && !start_i) |=> ($stable(index_o) && $stable(count_o) && $stable(flags_o)));

endmodule

// File: tb/test_strscan_seq.sv
module test_strscan_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic        wide_addr_i = 1'b1;
  logic        dir_i = 1'b0;
  logic [31:0] acc_i = '0;
  logic [31:0] index_i = '0;
  logic [31:0] count_i = '0;
  logic [1:0]  mode_i = 2'd0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] index_o;
  logic [31:0] count_o;
  logic [5:0]  flags_o;
  logic        busy_o;
  logic        done_o;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  strscan_seq i_strscan_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .wide_addr_i(wide_addr_i), .dir_i(dir_i), .acc_i(acc_i), .index_i(index_i),
    .count_i(count_i), .mode_i(mode_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .index_o(index_o),
    .count_o(count_o), .flags_o(flags_o), .busy_o(busy_o), .done_o(done_o)
  );

  logic [7:0] mem [256];

  function automatic logic [31:0] rd_mem(logic [31:0] a);
    logic [7:0] b;
    b = a[7:0];
    return {mem[8'(b + 8'd3)], mem[8'(b + 8'd2)], mem[8'(b + 8'd1)], mem[b]};
  endfunction

  function automatic logic [5:0] ref_flags(int sz, logic [31:0] a, logic [31:0] b);
    int          w;
    logic [63:0] m, av, bv, r;
    logic [5:0]  f;
    w  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m  = (64'd1 << w) - 64'd1;
    av = {32'd0, a} & m;
    bv = {32'd0, b} & m;
    r  = (av - bv) & m;
    f[0] = av < bv;
    f[1] = ~^r[7:0];
    f[2] = (av & 64'd15) < (bv & 64'd15);
    f[3] = (r == 64'd0);
    f[4] = r[w-1];
    f[5] = (av[w-1] != bv[w-1]) && (r[w-1] != av[w-1]);
    return f;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: 0 idle, 1 active, 2 done
  int          m_state = 0;
  logic [31:0] m_idx = '0, m_cnt = '0, m_acc = '0;
  logic [5:0]  m_flags = '0;
  int          m_sz = 0, m_mode = 0;
  logic        m_dir = 1'b0, m_wide = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_idx = '0; m_cnt = '0; m_flags = '0;
    end else if (m_state == 0) begin
      if (start_i) begin
        m_idx = index_i; m_cnt = count_i; m_acc = acc_i;
        m_sz = (size_i == 2'd3) ? 2 : int'(size_i);
        m_mode = int'(mode_i); m_dir = dir_i; m_wide = wide_addr_i;
        m_state = (m_mode != 0 && count_i == 0) ? 2 : 1;
      end
    end else if (m_state == 1) begin
      if (mem_rvalid_i) begin
        logic [31:0] nx;
        logic        stop;
        m_flags = ref_flags(m_sz, m_acc, mem_rdata_i);
        nx = m_dir ? m_idx - (32'd1 << m_sz) : m_idx + (32'd1 << m_sz);
        m_idx = m_wide ? nx : {m_idx[31:16], nx[15:0]};
        stop = (m_mode == 0);
        if (m_mode != 0) begin
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) stop = 1'b1;
          if (m_mode == 2 && !m_flags[3]) stop = 1'b1;
          if (m_mode == 3 && m_flags[3]) stop = 1'b1;
        end
        if (stop) m_state = 2;
      end
    end else begin
      m_state = 0;
    end
  end

  // Memory responder with a rotating latency of 0..2 cycles
  int wait_ctr = 0;
  int lat_tgt = 0;
  always @(negedge clk) begin
    if (mem_req_o) begin
      if (wait_ctr >= lat_tgt) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = rd_mem(mem_addr_o);
        wait_ctr = 0;
        lat_tgt = (lat_tgt + 1) % 3;
      end else begin
        mem_rvalid_i = 1'b0;
        wait_ctr++;
      end
    end else begin
      mem_rvalid_i = 1'b0;
      wait_ctr = 0;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] eaddr;
      eaddr = m_wide ? m_idx : {16'd0, m_idx[15:0]};
      chk("R6 req", {31'd0, mem_req_o}, {31'd0, m_state == 1});
      if (m_state == 1) chk("R6 addr", mem_addr_o, eaddr);
      chk("R4 index", index_o, m_idx);
      chk("R8 count", count_o, m_cnt);
      chk("R2 flags", {26'd0, flags_o}, {26'd0, m_flags});
      chk("R10 done", {31'd0, done_o}, {31'd0, m_state == 2});
      chk("R10 busy", {31'd0, busy_o}, {31'd0, m_state != 0});
    end
  end

  task automatic run(logic [1:0] sz, logic wide, logic dir, logic [31:0] acc,
                     logic [31:0] idx, logic [31:0] cnt, logic [1:0] mode);
    @(negedge clk);
    size_i = sz; wide_addr_i = wide; dir_i = dir; acc_i = acc;
    index_i = idx; count_i = cnt; mode_i = mode; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [5:0] prev_flags;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 16; i++) mem[8'h40 + i] = 8'h5A;
    mem[8'h45] = 8'h00;
    mem[8'h20] = 8'h20;
    mem[8'h21] = 8'h01;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 index", index_o, 32'd0);
    chk("R11 count", count_o, 32'd0);
    chk("R11 flags", {26'd0, flags_o}, 32'd0);
    chk("R11 idle", {29'd0, mem_req_o, busy_o, done_o}, 32'd0);

    // R1 / R7: byte once, upper accumulator bits ignored
    run(2'd0, 1'b1, 1'b0, 32'hFFFF_FF10, 32'h20, 32'd7, 2'd0);
    chk("R1 flags", {26'd0, flags_o}, 32'h13);
    chk("R7 count", count_o, 32'd7);
    chk("R4 index", index_o, 32'h21);

    // R3: borrow from bit 3 and odd parity, with signed overflow
    run(2'd0, 1'b1, 1'b0, 32'h80, 32'h21, 32'd0, 2'd0);
    chk("R3 flags", {26'd0, flags_o}, 32'h24);

    // R4: doubleword downward count loop
    run(2'd2, 1'b1, 1'b1, 32'h1234_5678, 32'h80, 32'd4, 2'd1);
    chk("R4 index", index_o, 32'h70);
    chk("R8 count", count_o, 32'd0);

    // R5: 16-bit wrap keeps upper bits
    run(2'd1, 1'b0, 1'b0, 32'h0000_1111, 32'hABCD_FFFE, 32'd3, 2'd1);
    chk("R5 index", index_o, 32'hABCD_0004);

    // R5: 32-bit carries into the upper half
    run(2'd1, 1'b1, 1'b0, 32'h0000_2222, 32'h0000_FFFE, 32'd3, 2'd1);
    chk("R5 index", index_o, 32'h0001_0004);

    // R9: while equal stops at the mismatch
    run(2'd0, 1'b1, 1'b0, 32'h5A, 32'h40, 32'd16, 2'd2);
    chk("R9 index", index_o, 32'h46);
    chk("R9 count", count_o, 32'd10);
    chk("R9 zf", {31'd0, flags_o[3]}, 32'd0);

    // R9: while not equal stops at the match
    run(2'd0, 1'b1, 1'b0, 32'h00, 32'h40, 32'd16, 2'd3);
    chk("R9 index", index_o, 32'h46);
    chk("R9 zf", {31'd0, flags_o[3]}, 32'd1);

    // R8: zero starting count keeps the flags
    prev_flags = flags_o;
    run(2'd2, 1'b1, 1'b0, 32'h0, 32'h99, 32'd0, 2'd1);
    chk("R8 flags", {26'd0, flags_o}, {26'd0, prev_flags});
    chk("R8 index", index_o, 32'h99);

    // R10: start while busy is ignored
    @(negedge clk);
    size_i = 2'd3; wide_addr_i = 1'b1; dir_i = 1'b0; acc_i = 32'h7;
    index_i = 32'h10; count_i = 32'd5; mode_i = 2'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    index_i = 32'hC0; count_i = 32'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk("R10 index", index_o, 32'h24);
    chk("R10 count", count_o, 32'd0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule